// File: doc/BRIEF.md
# Prioritised Eight-Line Interrupt Controller Core

This core gathers eight interrupt lines, plus the summary request from a downstream secondary controller, into one request register. Every line is captured on a rising edge or follows its level. The choice is made per line by a trigger-mode register, and a fixed per-instance mask limits which lines may be set to level mode. Pending requests are the captured requests minus the masked lines. A rotating priority resolver picks the winner. The core raises `int_o` when that winner outranks everything already in service.

The processor acknowledges a request with a one-cycle `inta_i` pulse and takes the vector from `vector_o` in the same cycle. A poll read has the same effect through the register port. An auto end-of-interrupt mode skips in-service tracking. It can also rotate priority, so that the line just served drops to the bottom. A reset command written through the register port clears all controller state except the trigger-mode register.

Top module: `pic_core`

## Requirements
- R1: An edge-mode line (trigger bit 0) sets its request bit only when the input is high and the stored previous level is low. The stored level then takes the input value. A request that stays high does not set the bit again after it has been acknowledged.
- R2: A level-mode line (trigger bit 1) has a request bit equal to the input as sampled on the last clock. An acknowledge does not clear it while the input stays high.
- R3: Pending is the request register with the mask bits removed (mask bit 1 = line masked). A masked line never raises `int_o` and is never the vector.
- R4: With no rotation, the lowest-numbered pending line wins. `int_o` is high exactly when a winner exists that outranks the highest-priority in-service line.
- R5: A write to address 2 stores the data ANDed with parameter `TRIG_MASK`. A read of address 2 returns the stored value.
- R6: The reset command (write to address 0 with bit 4 = 1) clears request, previous-level, mask, in-service, mode and rotation state. It leaves the trigger-mode register unchanged.
- R7: `vector_o` is `VEC_BASE` plus the winning line number. When there is no valid winner it is `VEC_BASE + 7`, and an acknowledge at that time changes no state.
- R8: An acknowledge of a valid winner clears its edge request bit and sets its in-service bit (read at address 3). The end-of-interrupt command (address 0, bit 4 = 0, bit 3 = 0, bit 5 = 1) clears the highest-priority in-service bit.
- R9: The mode command (address 0, bit 4 = 0, bit 3 = 1) loads auto-EOI from bit 0, rotate-on-auto-EOI from bit 1 and poll arm from bit 2. In auto-EOI mode an acknowledge sets no in-service bit. With rotation also set, the served line becomes lowest priority.
- R10: Address 1 writes and reads the mask register. A read of address 0 returns the request register unless poll is armed.
- R11: `cascade_i` is ORed into the input of line `CAS_LINE` before capture.
- R12: A poll read (read of address 0 with poll armed) returns 0x80 plus the winner line, or 0x00 when there is no valid winner. It acknowledges that line and disarms poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (clears everything, including the trigger-mode register) |
| irq_i | input | 8 | Interrupt request lines |
| cascade_i | input | 1 | Summary request from the secondary controller |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effects on poll only) |
| addr_i | input | 2 | Register address: 0 command/request, 1 mask, 2 trigger mode, 3 in-service |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from `addr_i` |
| int_o | output | 1 | Interrupt request to the processor |
| inta_i | input | 1 | One-cycle acknowledge pulse |
| vector_o | output | 8 | Vector for the current winner, or the spurious vector |

## Verification
Each line is driven alone through a full edge cycle: rise, acknowledge, hold high, then end-of-interrupt. This separates a new edge from a held level and checks the in-service bookkeeping line by line. All 256 request patterns are applied with no mask, and all 256 mask patterns are applied over a full request register. Together these pin the lowest-number priority order and show that masked lines never leak into the vector. Directed sequences cover the remaining behaviours: nested requests that are blocked and then released by end-of-interrupt, a level line held high through an acknowledge, auto-EOI with and without rotation, the cascade input, poll reads with and without a winner, and the reset command leaving the trigger-mode register intact.

// File: rtl/pic_core_pkg.sv
package pic_core_pkg;
  localparam int unsigned LINES  = 8;
  localparam int unsigned LINE_W = $clog2(LINES);

  typedef logic [LINES-1:0] line_vec_t;

  typedef enum logic [1:0] {
    ADDR_CMD  = 2'd0,
    ADDR_MASK = 2'd1,
    ADDR_TRIG = 2'd2,
    ADDR_ISR  = 2'd3
  } reg_addr_e;

  localparam int unsigned CMD_EOI_BIT   = 5;
  localparam int unsigned CMD_RESET_BIT = 4;
  localparam int unsigned CMD_MODE_BIT  = 3;
  localparam int unsigned MODE_POLL_BIT = 2;
  localparam int unsigned MODE_ROT_BIT  = 1;
  localparam int unsigned MODE_AEOI_BIT = 0;
endpackage

// File: rtl/pic_req_capture.sv
module pic_req_capture #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] trig_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] req_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic prev_q;
    logic req_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        req_q  <= 1'b0;
      end else if (clr_i) begin
        prev_q <= 1'b0;
        req_q  <= 1'b0;
      end else begin
        prev_q <= line_i[g];
        if (trig_i[g])                   req_q <= line_i[g];
        else if (line_i[g] && !prev_q)   req_q <= 1'b1;  // new edge beats ack
        else if (ack_i[g])               req_q <= 1'b0;
      end
    end
    assign req_o[g] = req_q;
  end
endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve #(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  input  logic [W-1:0] base_i,
  output logic         valid_o,
  output logic [W-1:0] line_o,
  output logic [W-1:0] rank_o
);
  // rank 0 = highest priority; line (base_i + rank) wraps modulo N
  always_comb begin
    logic [W-1:0] idx;
    valid_o = 1'b0;
    line_o  = '0;
    rank_o  = '0;
    idx     = '0;
    for (int k = N - 1; k >= 0; k--) begin
      idx = W'(base_i + W'(k));
      if (vec_i[idx]) begin
        valid_o = 1'b1;
        line_o  = idx;
        rank_o  = W'(k);
      end
    end
  end
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_core_pkg::*;
#(
  parameter logic [7:0]  TRIG_MASK = 8'hF8,
  parameter logic [7:0]  VEC_BASE  = 8'h20,
  parameter int unsigned CAS_LINE  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] irq_i,
  input  logic       cascade_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       int_o,
  input  logic       inta_i,
  output logic [7:0] vector_o
);
  line_vec_t irr, imr_q, isr_q, isr_d, trig_q, line_in, pend, ack_vec;
  logic              aeoi_q, rot_q, poll_q;
  logic [LINE_W-1:0] base_q;
  logic              p_valid, s_valid, req_ok;
  logic [LINE_W-1:0] p_line, p_rank, s_line, s_rank;
  logic              wr_cmd, soft_rst, mode_wr, eoi_wr, poll_rd, ack;

  assign line_in  = irq_i | (line_vec_t'(cascade_i) << CAS_LINE);

  assign wr_cmd   = wr_en_i && (addr_i == ADDR_CMD);
  assign soft_rst = wr_cmd && wdata_i[CMD_RESET_BIT];
  assign mode_wr  = wr_cmd && !wdata_i[CMD_RESET_BIT] && wdata_i[CMD_MODE_BIT];
  assign eoi_wr   = wr_cmd && !wdata_i[CMD_RESET_BIT] && !wdata_i[CMD_MODE_BIT]
                    && wdata_i[CMD_EOI_BIT];

  assign pend = irr & ~imr_q;

  pic_prio_resolve #(.N(LINES)) u_pend_res (
    .vec_i(pend), .base_i(base_q), .valid_o(p_valid), .line_o(p_line), .rank_o(p_rank)
  );
  pic_prio_resolve #(.N(LINES)) u_serv_res (
    .vec_i(isr_q), .base_i(base_q), .valid_o(s_valid), .line_o(s_line), .rank_o(s_rank)
  );

  assign req_ok  = p_valid && (!s_valid || (p_rank < s_rank));
  assign poll_rd = rd_en_i && (addr_i == ADDR_CMD) && poll_q;
  assign ack     = (inta_i || poll_rd) && req_ok;
  assign ack_vec = ack ? (line_vec_t'(1) << p_line) : '0;

  pic_req_capture #(.N(LINES)) u_capture (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (soft_rst),
    .line_i(line_in),
    .trig_i(trig_q),
    .ack_i (ack_vec),
    .req_o (irr)
  );

  always_comb begin
    isr_d = isr_q;
    if (eoi_wr && s_valid) isr_d[s_line] = 1'b0;
    if (!aeoi_q)           isr_d = isr_d | ack_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= '0;
    end else if (wr_en_i && (addr_i == ADDR_TRIG)) begin
      trig_q <= wdata_i & TRIG_MASK;
    end
  end

  // trig_q is kept out of this block: the reset command must not touch it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imr_q  <= '0;
      isr_q  <= '0;
      aeoi_q <= 1'b0;
      rot_q  <= 1'b0;
      poll_q <= 1'b0;
      base_q <= '0;
    end else if (soft_rst) begin
      imr_q  <= '0;
      isr_q  <= '0;
      aeoi_q <= 1'b0;
      rot_q  <= 1'b0;
      poll_q <= 1'b0;
      base_q <= '0;
    end else begin
      isr_q <= isr_d;
      if (wr_en_i && (addr_i == ADDR_MASK)) imr_q <= wdata_i;
      if (mode_wr) begin
        aeoi_q <= wdata_i[MODE_AEOI_BIT];
        rot_q  <= wdata_i[MODE_ROT_BIT];
        poll_q <= wdata_i[MODE_POLL_BIT];
      end else if (poll_rd) begin
        poll_q <= 1'b0;
      end
      if (ack && aeoi_q && rot_q) base_q <= LINE_W'(p_line + 1'b1);
    end
  end

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      ADDR_CMD:  rdata_o = poll_q ? (req_ok ? (8'h80 | 8'(p_line)) : 8'h00) : irr;
      ADDR_MASK: rdata_o = imr_q;
      ADDR_TRIG: rdata_o = trig_q;
      default:   rdata_o = isr_q;
    endcase
  end

  assign int_o    = req_ok;
  assign vector_o = VEC_BASE + (req_ok ? 8'(p_line) : 8'd7);
endmodule

// File: rtl/pic_core_chk.sv
module pic_core_chk #(
  parameter logic [7:0] VEC_BASE = 8'h20
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       int_o,
  input logic       inta_i,
  input logic       wr_en_i,
  input logic [1:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] vector_o,
  input logic [7:0] irr,
  input logic [7:0] imr_q,
  input logic [7:0] isr_q,
  input logic [7:0] trig_q,
  input logic       aeoi_q
);
  a_r3_int_needs_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((irr & ~imr_q) != 8'h00));

  a_r6_trig_survives_reset_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd0 && wdata_i[4]) |=> $stable(trig_q));

  a_r7_spurious_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !int_o) |-> (vector_o == VEC_BASE + 8'd7));

  a_r8_ack_sets_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && int_o && !aeoi_q && !wr_en_i) |=> isr_q[$past(vector_o[2:0])]);

  a_r8_one_new_isr_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(isr_q & ~$past(isr_q)) <= 1);

  a_r9_aeoi_keeps_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && int_o && aeoi_q && !wr_en_i) |=> (isr_q == $past(isr_q)));
endmodule

bind pic_core pic_core_chk #(.VEC_BASE(VEC_BASE)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .int_o   (int_o),
  .inta_i  (inta_i),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .vector_o(vector_o),
  .irr     (irr),
  .imr_q   (imr_q),
  .isr_q   (isr_q),
  .trig_q  (trig_q),
  .aeoi_q  (aeoi_q)
);

// File: tb/tb_pic_core.sv
module tb_pic_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       cas = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, inta = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, vector;
  logic       intr;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  localparam logic [7:0] VB = 8'h20;

  always #10 clk = ~clk;

  pic_core #(.TRIG_MASK(8'hF8), .VEC_BASE(VB), .CAS_LINE(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .cascade_i(cas), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .int_o(intr), .inta_i(inta), .vector_o(vector)
  );

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(input logic [7:0] p);
    irq = p; tick(); irq = '0; tick();
  endtask

  task automatic do_ack();
    inta = 1'b1; tick(); inta = 1'b0;
  endtask

  function automatic logic [7:0] low_vec(input logic [7:0] p);
    for (int b = 7; b >= 0; b--) if (p[b]) low_vec = VB + 8'(b);
    if (p == 8'h00) low_vec = VB + 8'd7;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // reset state
    chk8("reset int", {7'b0, intr}, 8'h00);
    rd(2'd0, d); chk8("reset irr", d, 8'h00);
    rd(2'd1, d); chk8("reset imr", d, 8'h00);
    rd(2'd2, d); chk8("reset trig", d, 8'h00);

    // R5 trigger write masked; R10 mask address; R6 reset command keeps trig
    wr(2'd2, 8'hFF);
    rd(2'd2, d); chk8("R5 trig mask", d, 8'hF8);
    wr(2'd1, 8'h5A);
    rd(2'd1, d); chk8("R10 mask readback", d, 8'h5A);
    wr(2'd0, 8'h09);
    wr(2'd0, 8'h10);
    rd(2'd2, d); chk8("R6 trig kept", d, 8'hF8);
    rd(2'd1, d); chk8("R6 mask cleared", d, 8'h00);
    wr(2'd2, 8'h00);

    // R1 per-line edge cycle, R8 ack and EOI
    for (int i = 0; i < 8; i++) begin
      irq = 8'(1) << i; tick();
      rd(2'd0, d); chk8("R1 edge captured", d, 8'(1) << i);
      chk8("R7 vector", vector, VB + 8'(i));
      do_ack();
      tick();
      rd(2'd0, d); chk8("R1 held level no retrigger", d, 8'h00);
      rd(2'd3, d); chk8("R8 isr set", d, 8'(1) << i);
      irq = '0;
      wr(2'd0, 8'h20);
      rd(2'd3, d); chk8("R8 eoi clears", d, 8'h00);
    end

    // R4 priority over all request patterns
    for (int p = 0; p < 256; p++) begin
      wr(2'd0, 8'h10);
      pulse(8'(p));
      chk8("R4 int", {7'b0, intr}, {7'b0, p != 0});
      chk8("R4 vector", vector, low_vec(8'(p)));
    end

    // R3 all mask patterns over full requests
    wr(2'd0, 8'h10);
    pulse(8'hFF);
    for (int m = 0; m < 256; m++) begin
      wr(2'd1, 8'(m));
      chk8("R3 int", {7'b0, intr}, {7'b0, m != 255});
      chk8("R3 vector", vector, low_vec(~8'(m)));
    end

    // R8 nesting
    wr(2'd0, 8'h10);
    pulse(8'h28);
    chk8("R8 first winner", vector, VB + 8'd3);
    do_ack();
    rd(2'd3, d); chk8("R8 isr line3", d, 8'h08);
    chk8("R8 lower blocked", {7'b0, intr}, 8'h00);
    pulse(8'h02);
    chk8("R8 higher preempts", {7'b0, intr}, 8'h01);
    chk8("R8 higher vector", vector, VB + 8'd1);
    do_ack();
    rd(2'd3, d); chk8("R8 nested isr", d, 8'h0A);
    wr(2'd0, 8'h20);
    rd(2'd3, d); chk8("R8 eoi highest first", d, 8'h08);
    chk8("R8 still blocked", {7'b0, intr}, 8'h00);
    wr(2'd0, 8'h20);
    chk8("R8 released", vector, VB + 8'd5);

    // R7 spurious
    wr(2'd0, 8'h10);
    inta = 1'b1; #1 chk8("R7 spurious vector", vector, VB + 8'd7);
    tick(); inta = 1'b0;
    rd(2'd3, d); chk8("R7 no isr change", d, 8'h00);

    // R2 level mode
    wr(2'd2, 8'h80);
    irq = 8'h80; tick();
    rd(2'd0, d); chk8("R2 level high", d, 8'h80);
    do_ack();
    rd(2'd0, d); chk8("R2 survives ack", d, 8'h80);
    irq = 8'h00; tick();
    rd(2'd0, d); chk8("R2 level low", d, 8'h00);
    wr(2'd2, 8'h00);

    // R9 auto-EOI
    wr(2'd0, 8'h10);
    wr(2'd0, 8'h09);
    pulse(8'h11);
    do_ack();
    rd(2'd3, d); chk8("R9 no isr", d, 8'h00);
    chk8("R9 next vector", vector, VB + 8'd4);
    // R9 rotation: serve line 2, then 5 outranks 0
    wr(2'd0, 8'h10);
    wr(2'd0, 8'h0B);
    pulse(8'h04);
    do_ack();
    pulse(8'h21);
    chk8("R9 rotated winner", vector, VB + 8'd5);

    // R11 cascade
    wr(2'd0, 8'h10);
    cas = 1'b1; tick(); cas = 1'b0; tick();
    rd(2'd0, d); chk8("R11 cascade req", d, 8'h04);
    chk8("R11 cascade vector", vector, VB + 8'd2);

    // R12 poll
    wr(2'd0, 8'h10);
    pulse(8'h40);
    wr(2'd0, 8'h0C);
    addr = 2'd0; rd_en = 1'b1;
    #1 chk8("R12 poll value", rdata, 8'h86);
    tick(); rd_en = 1'b0;
    rd(2'd3, d); chk8("R12 poll acks isr", d, 8'h40);
    rd(2'd0, d); chk8("R12 poll disarmed irr", d, 8'h00);
    wr(2'd0, 8'h0C);
    addr = 2'd0; rd_en = 1'b1;
    #1 chk8("R12 poll empty", rdata, 8'h00);
    tick(); rd_en = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule